// File: doc/BRIEF.md
# Six-Channel Transceiver Control Register Bank

This block holds one 16-bit control word for each channel of a multi-channel serial transceiver. A management agent reaches the words through a simple strobe port. It presents a channel index, a write or read strobe and, for writes, a data word. Bit 15 of a written word is a broadcast flag rather than a stored bit. When it is set, bits 14:0 are copied into every channel in the same clock edge. When it is clear, only the addressed channel takes the value. Bit 15 is never stored and always reads back as zero.

A synchronous reset reloads every channel with fixed defaults. The serial-interface mode bit is an exception: it takes the level of a board strap pin, sampled while reset is held. The bank also merges each channel's stored bits with per-channel board pins and drives the effective enables for the datapath. Two of the enables need both the register bit and the pin. Five of them need either one. The remaining bits drive their outputs directly.

Top module: `chan_ctrl_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every channel is loaded with its default word. Bits 14, 13, 12, 5 and 2 are 1. Bits 11:6, 3, 1 and 0 are 0. Bit 4 is described in R2. With the strap low a channel reads 16'h7024, and with the strap high it reads 16'h7034.
- R2: Bit 4 of each channel takes the level of `strap_sgmii` at the last reset edge. Later changes of the strap pin do not alter it. Only a write can change it after reset.
- R3: A write with `wr_data[15]`=0 to a valid index stores `wr_data[14:0]` into that channel only. All other channels keep their contents.
- R4: A write with `wr_data[15]`=1 to a valid index stores `wr_data[14:0]` into all channels at the same edge.
- R5: Bit 15 of `rd_data` is always 0.
- R6: A read strobe at a valid index puts `{1'b0, word[14:0]}` of that channel on `rd_data` one edge later. When reads and writes fall in the same cycle, the read returns the word as it stood before that edge. With `rd_en` low, `rd_data` holds its value.
- R7: Only indexes below 6 are valid. A write (broadcast or not) to index 6 or 7 changes no channel, and a read of index 6 or 7 returns 16'h0000.
- R8: `en_rate_comp[i]` is bit 13 AND `pin_rate_comp[i]`. `en_pcs[i]` is bit 12 AND `pin_pcs[i]`.
- R9: Each of these outputs is the register bit OR the matching pin of the same channel: `en_swap` (bit 11), `en_repeat` (bit 10), `en_prbs_chk` (bit 7), `en_prbs_gen` (bit 6) and `en_txclk_sel` (bit 3).
- R10: These outputs follow a single register bit each: `amp_full` (bit 14), `loop_near` (bit 9), `loop_far` (bit 8), `auto_rate` (bit 5), `sgmii_en` (bit 4) and `comma_en` (bit 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_sgmii | input | 1 | Board strap giving the reset value of bit 4 |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| ch_addr | input | 3 | Channel index |
| wr_data | input | 16 | Write word, bit 15 = broadcast |
| rd_data | output | 16 | Read word, registered |
| pin_rate_comp | input | 6 | Per-channel pin gating clock-tolerance compensation |
| pin_pcs | input | 6 | Per-channel pin gating the coding sublayer |
| pin_swap | input | 6 | Per-channel pin forcing pair swap |
| pin_repeat | input | 6 | Per-channel pin forcing repeat mode |
| pin_prbs | input | 6 | Per-channel pin forcing PRBS generator and checker |
| pin_txclk_sel | input | 6 | Per-channel pin forcing the local transmit clock |
| en_rate_comp | output | 6 | Effective clock-tolerance compensation enable |
| en_pcs | output | 6 | Effective coding sublayer enable |
| en_swap | output | 6 | Effective pair swap |
| en_repeat | output | 6 | Effective repeat mode |
| en_prbs_gen | output | 6 | Effective PRBS generator enable |
| en_prbs_chk | output | 6 | Effective PRBS checker enable |
| en_txclk_sel | output | 6 | Effective transmit clock select |
| amp_full | output | 6 | Full transmit amplitude |
| loop_near | output | 6 | Parallel-side loopback enable |
| loop_far | output | 6 | Serial-side loopback enable |
| auto_rate | output | 6 | Automatic rate sensing enable |
| sgmii_en | output | 6 | SGMII mode |
| comma_en | output | 6 | Comma detection enable |

## Verification
The checker watches several rules on every cycle:
- the top bit of the read word stays zero;
- the read register holds while no read is strobed;
- out-of-range reads return zero;
- no gated enable is ever high without its pin, and no ORed enable is ever low while its pin is high;
- a broadcast lands in all channels and a single write leaves the other channels alone;
- the strap bit holds while no write is made.

Only the bench's scenarios can show the exact stored values:
- the full reset word for both strap levels;
- the bits written into the addressed channel;
- out-of-range writes leaving every channel unchanged;
- the exact AND and OR results for random mixes of stored bits and pins.

// File: rtl/chan_ctrl_pkg.sv
package chan_ctrl_pkg;
   localparam int WORD_W      = 16;
   localparam int STORE_W     = WORD_W - 1;

   // field positions, fixed by the management software view
   localparam int F_BCAST     = 15;
   localparam int F_AMP       = 14;
   localparam int F_RCOMP     = 13;
   localparam int F_PCS       = 12;
   localparam int F_SWAP      = 11;
   localparam int F_REPEAT    = 10;
   localparam int F_NEAR      = 9;
   localparam int F_FAR       = 8;
   localparam int F_PCHK      = 7;
   localparam int F_PGEN      = 6;
   localparam int F_ASENSE    = 5;
   localparam int F_SGMII     = 4;
   localparam int F_TXCLK     = 3;
   localparam int F_COMMA     = 2;

   localparam logic [STORE_W-1:0] DEF_WORD = 15'h7024;

   function automatic logic [STORE_W-1:0] reset_word(input logic strap);
      logic [STORE_W-1:0] w;
      w = DEF_WORD;
      w[F_SGMII] = strap;
      return w;
   endfunction
endpackage

// File: rtl/chan_ctrl_slot.sv
module chan_ctrl_slot
   import chan_ctrl_pkg::*;
#(
   parameter int SW = STORE_W
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          strap,
   input  logic          we,
   input  logic [SW-1:0] wdata,
   output logic [SW-1:0] q
);
   generate
      if (SW != STORE_W) begin : g_bad_width
         $error("chan_ctrl_slot: SW must equal STORE_W");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         q <= reset_word(strap);
      else if (we)
         q <= wdata;
   end
endmodule

// File: rtl/chan_ctrl_merge.sv
module chan_ctrl_merge
   import chan_ctrl_pkg::*;
(
   input  logic [STORE_W-1:0] word,
   input  logic               p_rcomp,
   input  logic               p_pcs,
   input  logic               p_swap,
   input  logic               p_repeat,
   input  logic               p_prbs,
   input  logic               p_txclk,
   output logic               e_rcomp,
   output logic               e_pcs,
   output logic               e_swap,
   output logic               e_repeat,
   output logic               e_pgen,
   output logic               e_pchk,
   output logic               e_txclk,
   output logic               d_amp,
   output logic               d_near,
   output logic               d_far,
   output logic               d_asense,
   output logic               d_sgmii,
   output logic               d_comma
);
   always_comb begin
      // gated by pin: both must agree
      e_rcomp  = word[F_RCOMP]  & p_rcomp;
      e_pcs    = word[F_PCS]    & p_pcs;
      // forced by pin: either may enable
      e_swap   = word[F_SWAP]   | p_swap;
      e_repeat = word[F_REPEAT] | p_repeat;
      e_pgen   = word[F_PGEN]   | p_prbs;
      e_pchk   = word[F_PCHK]   | p_prbs;
      e_txclk  = word[F_TXCLK]  | p_txclk;
      // register only
      d_amp    = word[F_AMP];
      d_near   = word[F_NEAR];
      d_far    = word[F_FAR];
      d_asense = word[F_ASENSE];
      d_sgmii  = word[F_SGMII];
      d_comma  = word[F_COMMA];
   end
endmodule

// File: rtl/chan_ctrl_bank.sv
module chan_ctrl_bank
   import chan_ctrl_pkg::*;
#(
   parameter int NUM_CH = 6,
   parameter int ADDR_W = 3,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              strap_sgmii,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] ch_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [NUM_CH-1:0] pin_rate_comp,
   input  logic [NUM_CH-1:0] pin_pcs,
   input  logic [NUM_CH-1:0] pin_swap,
   input  logic [NUM_CH-1:0] pin_repeat,
   input  logic [NUM_CH-1:0] pin_prbs,
   input  logic [NUM_CH-1:0] pin_txclk_sel,
   output logic [NUM_CH-1:0] en_rate_comp,
   output logic [NUM_CH-1:0] en_pcs,
   output logic [NUM_CH-1:0] en_swap,
   output logic [NUM_CH-1:0] en_repeat,
   output logic [NUM_CH-1:0] en_prbs_gen,
   output logic [NUM_CH-1:0] en_prbs_chk,
   output logic [NUM_CH-1:0] en_txclk_sel,
   output logic [NUM_CH-1:0] amp_full,
   output logic [NUM_CH-1:0] loop_near,
   output logic [NUM_CH-1:0] loop_far,
   output logic [NUM_CH-1:0] auto_rate,
   output logic [NUM_CH-1:0] sgmii_en,
   output logic [NUM_CH-1:0] comma_en
);
   localparam int SW = DATA_W - 1;

   generate
      if (DATA_W != WORD_W) begin : g_bad_data_w
         $error("chan_ctrl_bank: DATA_W must be 16");
      end
      if (NUM_CH < 1 || NUM_CH > (1 << ADDR_W)) begin : g_bad_ch
         $error("chan_ctrl_bank: NUM_CH does not fit ADDR_W");
      end
   endgenerate

   logic              addr_ok;
   logic [NUM_CH-1:0] wsel;
   logic [SW-1:0]     words [NUM_CH];

   assign addr_ok = ({1'b0, ch_addr} < (ADDR_W + 1)'(NUM_CH));

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
         assign wsel[gi] = wr_en & addr_ok &
                           (wr_data[F_BCAST] | (ch_addr == ADDR_W'(gi)));

         chan_ctrl_slot #(.SW(SW)) u_slot (
            .clk   (clk),
            .rst   (rst),
            .strap (strap_sgmii),
            .we    (wsel[gi]),
            .wdata (wr_data[SW-1:0]),
            .q     (words[gi])
         );

         chan_ctrl_merge u_merge (
            .word     (words[gi]),
            .p_rcomp  (pin_rate_comp[gi]),
            .p_pcs    (pin_pcs[gi]),
            .p_swap   (pin_swap[gi]),
            .p_repeat (pin_repeat[gi]),
            .p_prbs   (pin_prbs[gi]),
            .p_txclk  (pin_txclk_sel[gi]),
            .e_rcomp  (en_rate_comp[gi]),
            .e_pcs    (en_pcs[gi]),
            .e_swap   (en_swap[gi]),
            .e_repeat (en_repeat[gi]),
            .e_pgen   (en_prbs_gen[gi]),
            .e_pchk   (en_prbs_chk[gi]),
            .e_txclk  (en_txclk_sel[gi]),
            .d_amp    (amp_full[gi]),
            .d_near   (loop_near[gi]),
            .d_far    (loop_far[gi]),
            .d_asense (auto_rate[gi]),
            .d_sgmii  (sgmii_en[gi]),
            .d_comma  (comma_en[gi])
         );
      end
   endgenerate

   logic [SW-1:0] rd_pick;

   always_comb begin
      rd_pick = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (ch_addr == ADDR_W'(i))
            rd_pick = words[i];
   end

   always_ff @(posedge clk) begin
      if (rst)
         rd_data <= '0;
      else if (rd_en)
         rd_data <= {1'b0, (addr_ok ? rd_pick : {SW{1'b0}})};
   end
endmodule

// File: rtl/chan_ctrl_bank_chk.sv
module chan_ctrl_bank_chk #(
   parameter int NUM_CH = 6,
   parameter int ADDR_W = 3,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] ch_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic [NUM_CH-1:0] pin_rate_comp,
   input logic [NUM_CH-1:0] pin_pcs,
   input logic [NUM_CH-1:0] pin_swap,
   input logic [NUM_CH-1:0] en_rate_comp,
   input logic [NUM_CH-1:0] en_pcs,
   input logic [NUM_CH-1:0] en_swap,
   input logic [NUM_CH-1:0] amp_full,
   input logic [NUM_CH-1:0] loop_near,
   input logic [NUM_CH-1:0] sgmii_en
);
   logic valid_idx;
   assign valid_idx = ({1'b0, ch_addr} < (ADDR_W + 1)'(NUM_CH));

   // R1
   reset_defaults_chk: assert property (@(posedge clk)
      rst |=> (amp_full == '1 && loop_near == '0));

   // R2
   strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && valid_idx) |=> $stable(sgmii_en));

   // R3
   single_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && valid_idx && !wr_data[DATA_W-1]) |=>
      (((amp_full ^ $past(amp_full)) & ~(NUM_CH'(1) << $past(ch_addr))) == '0));

   // R4
   bcast_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && valid_idx && wr_data[DATA_W-1]) |=>
      (amp_full == {NUM_CH{$past(wr_data[DATA_W-2])}}));

   // R5
   top_bit_zero_chk: assert property (@(posedge clk) disable iff (rst)
      rd_data[DATA_W-1] == 1'b0);

   // R6
   read_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> $stable(rd_data));

   // R7
   bad_index_read_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_en && !valid_idx) |=> rd_data == '0);

   // R8
   and_gate_chk: assert property (@(posedge clk) disable iff (rst)
      ((en_rate_comp & ~pin_rate_comp) | (en_pcs & ~pin_pcs)) == '0);

   // R9
   or_force_chk: assert property (@(posedge clk) disable iff (rst)
      (pin_swap & ~en_swap) == '0);
endmodule

bind chan_ctrl_bank chan_ctrl_bank_chk #(
   .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .ch_addr(ch_addr),
   .wr_data(wr_data), .rd_data(rd_data), .pin_rate_comp(pin_rate_comp),
   .pin_pcs(pin_pcs), .pin_swap(pin_swap), .en_rate_comp(en_rate_comp),
   .en_pcs(en_pcs), .en_swap(en_swap), .amp_full(amp_full),
   .loop_near(loop_near), .sgmii_en(sgmii_en)
);

// File: tb/chan_ctrl_bank_test.sv
`timescale 1ns/1ps
module chan_ctrl_bank_test;
   localparam int N = 6;

   logic        clk = 0;
   logic        rst = 1;
   logic        strap_sgmii = 1;
   logic        wr_en = 0, rd_en = 0;
   logic [2:0]  ch_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [N-1:0] p_rc = 0, p_pcs = 0, p_sw = 0, p_rp = 0, p_pr = 0, p_tc = 0;
   logic [N-1:0] e_rc, e_pcs, e_sw, e_rp, e_pg, e_pk, e_tc;
   logic [N-1:0] o_amp, o_near, o_far, o_asn, o_sg, o_cm;

   int checks = 0, fails = 0;
   logic [15:0] model [N];

   always #5 clk = ~clk;

   chan_ctrl_bank uut (
      .clk(clk), .rst(rst), .strap_sgmii(strap_sgmii), .wr_en(wr_en),
      .rd_en(rd_en), .ch_addr(ch_addr), .wr_data(wr_data), .rd_data(rd_data),
      .pin_rate_comp(p_rc), .pin_pcs(p_pcs), .pin_swap(p_sw),
      .pin_repeat(p_rp), .pin_prbs(p_pr), .pin_txclk_sel(p_tc),
      .en_rate_comp(e_rc), .en_pcs(e_pcs), .en_swap(e_sw), .en_repeat(e_rp),
      .en_prbs_gen(e_pg), .en_prbs_chk(e_pk), .en_txclk_sel(e_tc),
      .amp_full(o_amp), .loop_near(o_near), .loop_far(o_far),
      .auto_rate(o_asn), .sgmii_en(o_sg), .comma_en(o_cm)
   );

   function automatic logic [15:0] dflt(input logic s);
      return s ? 16'h7034 : 16'h7024;
   endfunction

   function automatic logic [N-1:0] col(input int b);
      logic [N-1:0] v;
      for (int c = 0; c < N; c++) v[c] = model[c][b];
      return v;
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic do_write(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      ch_addr = a; wr_data = d; wr_en = 1;
      @(negedge clk);
      wr_en = 0;
      if (a < N) begin
         for (int c = 0; c < N; c++)
            if (d[15] || c == int'(a)) model[c] = {1'b0, d[14:0]};
      end
   endtask

   task automatic do_read(input logic [2:0] a, input string req);
      @(negedge clk);
      ch_addr = a; rd_en = 1;
      @(negedge clk);
      rd_en = 0;
      chk(req, rd_data, (a < N) ? model[a] : 16'h0000);
   endtask

   task automatic check_pins();
      #1;
      chk("R8 rate_comp", e_rc, col(13) & p_rc);
      chk("R8 pcs", e_pcs, col(12) & p_pcs);
      chk("R9 swap", e_sw, col(11) | p_sw);
      chk("R9 repeat", e_rp, col(10) | p_rp);
      chk("R9 prbs_chk", e_pk, col(7) | p_pr);
      chk("R9 prbs_gen", e_pg, col(6) | p_pr);
      chk("R9 txclk", e_tc, col(3) | p_tc);
      chk("R10 direct", {o_amp, o_near, o_far, o_asn, o_sg, o_cm},
          {col(14), col(9), col(8), col(5), col(4), col(2)});
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] held;
      void'($urandom(32'd20240611));
      // reset with strap high
      repeat (3) @(negedge clk);
      rst = 0;
      for (int c = 0; c < N; c++) model[c] = dflt(1'b1);
      for (int c = 0; c < N; c++) do_read(3'(c), "R1 default strap=1");
      check_pins();
      // R2: strap changes after reset have no effect
      strap_sgmii = 0;
      repeat (4) @(negedge clk);
      do_read(3'd3, "R2 strap held after reset");
      // reset again with strap low
      @(negedge clk); rst = 1;
      repeat (2) @(negedge clk); rst = 0;
      for (int c = 0; c < N; c++) model[c] = dflt(1'b0);
      do_read(3'd0, "R1 default strap=0");
      do_read(3'd5, "R1 default strap=0");
      // R7 invalid index
      do_read(3'd6, "R7 read idx 6");
      do_read(3'd7, "R7 read idx 7");
      do_write(3'd6, 16'h8000);
      do_write(3'd7, 16'h0ABC);
      for (int c = 0; c < N; c++) do_read(3'(c), "R7 write idx 6/7 ignored");
      // R3 single write, R5 top bit
      do_write(3'd2, 16'h7FFF);
      for (int c = 0; c < N; c++) do_read(3'(c), "R3 single write");
      do_write(3'd4, 16'hFFFF & 16'h7F0F);
      do_read(3'd4, "R5 top bit zero");
      // R4 broadcast
      do_write(3'd1, 16'h8155);
      for (int c = 0; c < N; c++) do_read(3'(c), "R4 broadcast");
      p_rc = '1; p_pcs = '1; check_pins();
      // R6 hold with rd_en low
      do_write(3'd0, 16'h0003);
      do_read(3'd0, "R6 read latency");
      held = rd_data;
      @(negedge clk); ch_addr = 3'd5;
      repeat (2) @(negedge clk);
      chk("R6 hold when idle", rd_data, held);
      // R6 read and write same cycle returns old word
      @(negedge clk);
      ch_addr = 3'd0; wr_data = 16'h1234; wr_en = 1; rd_en = 1;
      @(negedge clk);
      wr_en = 0; rd_en = 0;
      chk("R6 read before write", rd_data, model[0]);
      model[0] = 16'h1234;
      do_read(3'd0, "R6 read after write");
      // constrained random
      for (int k = 0; k < 300; k++) begin
         logic [2:0]  a;
         logic [15:0] d;
         a = 3'($urandom_range(0, 7));
         d = 16'($urandom());
         d[15] = ($urandom_range(0, 5) == 0);
         if ($urandom_range(0, 1) == 0) do_write(a, d);
         else do_read(a, "R3/R4/R7 random read");
         @(negedge clk);
         p_rc = N'($urandom()); p_pcs = N'($urandom()); p_sw = N'($urandom());
         p_rp = N'($urandom()); p_pr = N'($urandom()); p_tc = N'($urandom());
         if (k % 10 == 0) check_pins();
      end
      for (int c = 0; c < N; c++) do_read(3'(c), "R3/R4 final state");
      check_pins();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule